// File: doc/BRIEF.md
# Ternary Prefix Match Table

This block is a small ternary match table for route lookup. Each row holds a stored pattern, a care mask, a result code and a valid flag. A search presents a key, and every valid row compares the key with its pattern in the same cycle. A mask bit of 1 makes that bit significant. A mask bit of 0 makes the bit a wildcard. Among the rows that match, the one with the lowest index wins. Its result code and index are returned one clock later.

To get longest-prefix routing, software places longer prefixes at lower indices than shorter ones. A catch-all row with an all-zero mask at the last index then serves as the default route. A write port loads, overwrites or clears one row by index. The change takes effect at the clock edge, so a search issued in the same cycle as a write still sees the old contents of the row.

The response side is a three-state machine:

| State | Meaning |
|-------|---------|
| `ST_IDLE` | No response this cycle |
| `ST_HIT` | Response with a match |
| `ST_MISS` | Response with no match |

On every clock the machine moves from any state to:
- `ST_HIT` when a search is requested and some row matches;
- `ST_MISS` when a search is requested and no row matches;
- `ST_IDLE` when no search is requested.

Top module: `tcam_lpm`

## Requirements
- R1: A row matches a key when, for every bit where its mask is 1, the key bit equals the stored bit. Key bits where the mask is 0 are ignored.
- R2: A row whose valid flag is clear never matches, whatever its pattern and mask.
- R3: When several rows match, the lowest-index row wins. `rsp_index` reports that row and `rsp_result` reports its result code.
- R4: A search with no matching row gives `rsp_valid`=1, `rsp_hit`=0, `rsp_result`=0 and `rsp_index`=0.
- R5: `rsp_valid` is 1 exactly in the cycle after `srch_en` was 1. While `rsp_valid` is 0, `rsp_hit` and `rsp_result` are 0.
- R6: A write with `wr_en`=1 and `wr_valid`=1 replaces the pattern, mask and result of row `wr_idx` at the clock edge. A search in the same cycle as the write uses the previous contents; searches from the next cycle on use the new ones.
- R7: A write with `wr_valid`=0 clears row `wr_idx`, so it no longer matches from the next cycle on.
- R8: After reset every row is invalid and all response outputs are 0.
- R9: With a full-length prefix at index 0, a 4-bit prefix at index 3 and an all-wildcard row at index 7, each key resolves to the longest prefix that covers it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | IDX_W | Row to write |
| wr_valid | input | 1 | 1 loads the row, 0 clears it |
| wr_value | input | KEY_W | Stored pattern |
| wr_mask | input | KEY_W | Care mask, 1 = significant bit |
| wr_result | input | RES_W | Result code of the row |
| srch_en | input | 1 | Search request |
| srch_key | input | KEY_W | Search key |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Some row matched |
| rsp_result | output | RES_W | Result of the winning row, 0 on a miss |
| rsp_index | output | IDX_W | Index of the winning row, 0 on a miss |

## Verification
A write and a search can fall in the same cycle, and they may even target the same row. The bench provokes this by raising `wr_en` and `srch_en` at the same falling edge. The write replaces a row that the search key currently hits. The response is judged correct only if it carries the row's old result code, and a second search right after must return the new code. The bench also clears the highest-priority row and then confirms that the lookup falls through to the next prefix.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIT  = 2'd1,
        ST_MISS = 2'd2
    } rsp_state_e;
endpackage

// File: rtl/tcam_row.sv
module tcam_row #(
    parameter int KEY_W = 8,
    parameter int RES_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sel,
    input  logic             wr_valid,
    input  logic [KEY_W-1:0] wr_value,
    input  logic [KEY_W-1:0] wr_mask,
    input  logic [RES_W-1:0] wr_result,
    input  logic [KEY_W-1:0] key,
    output logic             match,
    output logic [RES_W-1:0] result
);
    logic             valid_q;
    logic [KEY_W-1:0] value_q;
    logic [KEY_W-1:0] mask_q;
    logic [RES_W-1:0] result_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            value_q  <= '0;
            mask_q   <= '0;
            result_q <= '0;
        end else if (wr_sel) begin
            valid_q  <= wr_valid;
            value_q  <= wr_value;
            mask_q   <= wr_mask;
            result_q <= wr_result;
        end
    end

    // ternary compare: only masked-in bits must agree
    assign match  = valid_q && (((key ^ value_q) & mask_q) == '0);
    assign result = result_q;

    // R7
    clear_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && !wr_valid) |=> !match);
endmodule

// File: rtl/tcam_prio.sv
module tcam_prio #(
    parameter int N = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx,
    output logic [N-1:0]     grant
);
    always_comb begin
        idx   = '0;
        grant = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx   = IDX_W'(i);
                grant = '0;
                grant[i] = 1'b1;
            end
        end
        any = |req;
    end

    // R3
    always_comb begin
        single_grant_chk: assert ($onehot0(grant));
        grant_in_req_chk: assert ((grant & ~req) == '0);
    end
endmodule

// File: rtl/tcam_lpm.sv
module tcam_lpm #(
    parameter int KEY_W = 8,
    parameter int RES_W = 4,
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic [KEY_W-1:0] wr_value,
    input  logic [KEY_W-1:0] wr_mask,
    input  logic [RES_W-1:0] wr_result,
    input  logic             srch_en,
    input  logic [KEY_W-1:0] srch_key,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [RES_W-1:0] rsp_result,
    output logic [IDX_W-1:0] rsp_index
);
    import tcam_pkg::*;

    logic [DEPTH-1:0] row_match;
    logic [DEPTH-1:0] row_grant;
    logic [RES_W-1:0] row_res [DEPTH];
    logic             any_match;
    logic [IDX_W-1:0] win_idx;
    logic [RES_W-1:0] win_res;

    rsp_state_e state_q, state_d;
    logic [RES_W-1:0] res_q;
    logic [IDX_W-1:0] idx_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        tcam_row #(.KEY_W(KEY_W), .RES_W(RES_W)) row_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_sel   (wr_en && (wr_idx == IDX_W'(g))),
            .wr_valid (wr_valid),
            .wr_value (wr_value),
            .wr_mask  (wr_mask),
            .wr_result(wr_result),
            .key      (srch_key),
            .match    (row_match[g]),
            .result   (row_res[g])
        );
    end

    tcam_prio #(.N(DEPTH)) prio_i (
        .req  (row_match),
        .any  (any_match),
        .idx  (win_idx),
        .grant(row_grant)
    );

    // AND-OR select driven by the one-hot grant
    always_comb begin
        win_res = '0;
        for (int i = 0; i < DEPTH; i++) begin
            win_res = win_res | (row_res[i] & {RES_W{row_grant[i]}});
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE, ST_HIT, ST_MISS: begin
                if (!srch_en)       state_d = ST_IDLE;
                else if (any_match) state_d = ST_HIT;
                else                state_d = ST_MISS;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            idx_q <= '0;
        end else begin
            unique case (state_d)
                ST_HIT: begin
                    res_q <= win_res;
                    idx_q <= win_idx;
                end
                default: begin
                    res_q <= '0;
                    idx_q <= '0;
                end
            endcase
        end
    end

    assign rsp_valid  = (state_q != ST_IDLE);
    assign rsp_hit    = (state_q == ST_HIT);
    assign rsp_result = res_q;
    assign rsp_index  = idx_q;

    // R5
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srch_en |=> rsp_valid);
    // R5
    no_req_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !srch_en |=> !rsp_valid);
    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && rsp_result == '0));
    // R4
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_result == '0 && rsp_index == '0));
endmodule

// File: tb/tcam_lpm_tb_top.sv
module tcam_lpm_tb_top;
    localparam int KEY_W = 8;
    localparam int RES_W = 4;
    localparam int DEPTH = 8;
    localparam int IDX_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [IDX_W-1:0] wr_idx = '0;
    logic             wr_valid = 1'b0;
    logic [KEY_W-1:0] wr_value = '0;
    logic [KEY_W-1:0] wr_mask = '0;
    logic [RES_W-1:0] wr_result = '0;
    logic             srch_en = 1'b0;
    logic [KEY_W-1:0] srch_key = '0;
    logic             rsp_valid, rsp_hit;
    logic [RES_W-1:0] rsp_result;
    logic [IDX_W-1:0] rsp_index;

    int n_chk = 0;
    int n_bad = 0;

    logic             m_valid [DEPTH];
    logic [KEY_W-1:0] m_value [DEPTH];
    logic [KEY_W-1:0] m_mask  [DEPTH];
    logic [RES_W-1:0] m_res   [DEPTH];

    always #5 clk = ~clk;

    tcam_lpm #(.KEY_W(KEY_W), .RES_W(RES_W), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
        .wr_value(wr_value), .wr_mask(wr_mask), .wr_result(wr_result),
        .srch_en(srch_en), .srch_key(srch_key),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_result(rsp_result), .rsp_index(rsp_index)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_lookup(input logic [KEY_W-1:0] key, output int hit,
                                output int res, output int idx);
        hit = 0; res = 0; idx = 0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (m_valid[i] && (((key ^ m_value[i]) & m_mask[i]) == '0)) begin
                hit = 1; res = int'(m_res[i]); idx = i;
            end
        end
    endtask

    task automatic do_write(input int idx, input logic v, input logic [KEY_W-1:0] val,
                            input logic [KEY_W-1:0] msk, input logic [RES_W-1:0] res);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_valid = v;
        wr_value = val; wr_mask = msk; wr_result = res;
        @(negedge clk);
        wr_en = 1'b0;
        m_valid[idx] = v; m_value[idx] = val; m_mask[idx] = msk; m_res[idx] = res;
    endtask

    task automatic do_search(input logic [KEY_W-1:0] key, input string req);
        int eh, er, ei;
        model_lookup(key, eh, er, ei);
        @(negedge clk);
        srch_en = 1'b1; srch_key = key;
        @(negedge clk);
        srch_en = 1'b0;
        check({req, " valid"}, int'(rsp_valid), 1);
        check({req, " hit"}, int'(rsp_hit), eh);
        check({req, " result"}, int'(rsp_result), er);
        check({req, " index"}, int'(rsp_index), ei);
    endtask

    task automatic t_reset;
        check("R8 valid after reset", int'(rsp_valid), 0);
        check("R8 hit after reset", int'(rsp_hit), 0);
        check("R8 result after reset", int'(rsp_result), 0);
        do_search(8'h00, "R8 empty table R4");
        do_search(8'hFF, "R2 empty table all ones");
    endtask

    task automatic t_ternary;
        do_write(2, 1'b1, 8'hA0, 8'hF0, 4'd5);
        do_search(8'hA7, "R1 wildcard low nibble");
        do_search(8'hAF, "R1 wildcard all ones low");
        do_search(8'hB0, "R1 care bit differs R4");
        check("R1 miss expected", int'(rsp_hit), 0);
    endtask

    task automatic t_prefix;
        do_write(0, 1'b1, 8'hC3, 8'hFF, 4'd1);
        do_write(3, 1'b1, 8'hC0, 8'hF0, 4'd3);
        do_write(7, 1'b1, 8'h00, 8'h00, 4'd7);
        do_search(8'hC3, "R9 R3 full prefix wins");
        check("R3 index 0", int'(rsp_index), 0);
        do_search(8'hC5, "R9 nibble prefix");
        check("R9 result 3", int'(rsp_result), 3);
        do_search(8'h15, "R9 default route");
        check("R9 result 7", int'(rsp_result), 7);
        do_search(8'hA1, "R3 row2 beats default");
        check("R3 index 2", int'(rsp_index), 2);
    endtask

    task automatic t_clear;
        do_write(0, 1'b0, 8'hC3, 8'hFF, 4'd1);
        do_search(8'hC3, "R7 R2 cleared row skipped");
        check("R7 falls to row 3", int'(rsp_index), 3);
    endtask

    task automatic t_overlap;
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd3; wr_valid = 1'b1;
        wr_value = 8'hC0; wr_mask = 8'hF0; wr_result = 4'd9;
        srch_en = 1'b1; srch_key = 8'hC5;
        @(negedge clk);
        wr_en = 1'b0; srch_en = 1'b0;
        check("R6 same-cycle hit", int'(rsp_hit), 1);
        check("R6 same-cycle old result", int'(rsp_result), 3);
        m_res[3] = 4'd9;
        do_search(8'hC5, "R6 new contents");
        check("R6 new result", int'(rsp_result), 9);
    endtask

    task automatic t_latency;
        @(negedge clk);
        srch_en = 1'b1; srch_key = 8'hC5;
        check("R5 no response before edge", int'(rsp_valid), 0);
        @(negedge clk);
        srch_en = 1'b0;
        check("R5 response one cycle later", int'(rsp_valid), 1);
        @(negedge clk);
        check("R5 response drops", int'(rsp_valid), 0);
        check("R5 idle hit zero", int'(rsp_hit), 0);
        check("R5 idle result zero", int'(rsp_result), 0);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            m_valid[i] = 1'b0; m_value[i] = '0; m_mask[i] = '0; m_res[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ternary();
        t_prefix();
        t_clear();
        t_overlap();
        t_latency();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R5 watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule